// File: doc/BRIEF.md
# Scanline Edge IRQ Counter

This block counts rising edges on bit 12 of the picture processor's address bus and raises an interrupt request once a programmed number of edges has passed. The CPU programs it through four write-only registers. One sets a reload value. One forces the counter to zero. One acknowledges and disables the interrupt. One enables it. The counter is 8 bits wide. It counts down, and it reloads itself on the edge that follows zero, so it runs without a stop for as long as the address line toggles. The CPU cannot read it.

The A12 input is asynchronous to the system clock. It passes through a synchroniser, and its rising edges are detected in the system clock domain. A gate input lets edges count only while it is high. The gate is expected to be the OR of the two pattern-table select bits of the picture processor's control register. It is sampled on the system clock.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write with address bits [15:13] = 110 and address bit 0 = 0 stores the data byte as the reload value. It leaves the counter unchanged. The stored value is used only when a later counting edge reloads the counter.
- R2: A write with address bits [15:13] = 110 and address bit 0 = 1 forces the counter to zero, whatever the data. The next counting edge loads the reload value.
- R3: On each counting edge, a counter at zero loads the reload value, and any other counter value decrements by one.
- R4: When a counting edge leaves the counter at zero and the interrupt is enabled, irq_o goes high. After a clear with reload value N, it goes high on the (N+1)th edge.
- R5: A write with address bits [15:13] = 111 and address bit 0 = 0 drives irq_o low and disables the interrupt. It does not change the counter.
- R6: A write with address bits [15:13] = 111 and address bit 0 = 1 enables the interrupt, and it does not change the counter. While the interrupt is disabled, reaching zero raises nothing, and enabling it later does not raise a missed request.
- R7: The counter never stops. With a reload value of 0, every counting edge raises irq_o again.
- R8: A rising edge of A12 counts only if gate_i is high. While gate_i is low, edges change nothing.
- R9: Once irq_o is high, it stays high until it is acknowledged. Reset clears the counter, the reload value, the enable and irq_o.
- R10: Only a low-to-high transition of A12 counts, once per transition. A high level held for many clocks counts once, and a falling edge does not count.
- R11: Writes to addresses outside the two register regions leave the counter and irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wr_i | input | 1 | Write strobe, one cycle for each write |
| data_i | input | 8 | CPU write data |
| a12_i | input | 1 | Address bit 12 of the picture processor (asynchronous) |
| gate_i | input | 1 | Count gate. Edges count only while it is high |
| irq_o | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
The assertions check the following on every cycle:
- a clear leaves the counter at zero;
- a gated-off cycle leaves the counter unchanged;
- a reload write alone never moves the counter;
- a counting edge decrements a nonzero counter;
- irq_o rises only with the counter at zero;
- an acknowledge always drops the request;
- a pending request holds until it is acknowledged.

Only the bench's edge-counting scenarios can show the following:
- the exact number of edges to an interrupt after a clear or a reload;
- that the reload value is taken at reload time rather than at write time;
- that a long high level counts once;
- that a disabled interrupt is not raised after the fact.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RELOAD,
    CMD_CLEAR,
    CMD_ACK,
    CMD_EN
  } irq_cmd_e;

  localparam logic [2:0] REGION_CNT = 3'b110;
  localparam logic [2:0] REGION_IRQ = 3'b111;
endpackage

// File: rtl/sirq_edge_det.sv
module sirq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= sig_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/sirq_reg_decode.sv
module sirq_reg_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output irq_cmd_e          cmd_o
);
  localparam int TOP = ADDR_W - 1;

  logic [2:0] region;
  assign region = addr_i[TOP -: 3];

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i) begin
      unique case (region)
        REGION_CNT: cmd_o = addr_i[0] ? CMD_CLEAR : CMD_RELOAD;
        REGION_IRQ: cmd_o = addr_i[0] ? CMD_EN : CMD_ACK;
        default:    cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sirq_down_counter.sv
module sirq_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] latch_q, cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (step_i)          cnt_d = (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
  end

  // clear takes priority over an edge in the same cycle
  assign hit_o = step_i & ~clr_i & (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (reload_wr_i) latch_q <= reload_val_i;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              a12_i,
  input  logic              gate_i,
  output logic              irq_o
);
  irq_cmd_e          cmd;
  logic              a12_rise, step, hit;
  logic [DATA_W-1:0] cnt;
  logic              en_q, flag_q;

  sirq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (a12_i),
    .rise_o(a12_rise)
  );

  sirq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i  (wr_i),
    .addr_i(addr_i),
    .cmd_o (cmd)
  );

  assign step = a12_rise & gate_i;

  sirq_down_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_wr_i (cmd == CMD_RELOAD),
    .reload_val_i(data_i),
    .clr_i       (cmd == CMD_CLEAR),
    .step_i      (step),
    .cnt_o       (cnt),
    .hit_o       (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (cmd == CMD_ACK) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cmd == CMD_EN) en_q <= 1'b1;
      if (hit && en_q)   flag_q <= 1'b1;
    end
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk
  import scanline_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              gate_i,
  input logic              edge_i,
  input irq_cmd_e          cmd_i,
  input logic [DATA_W-1:0] cnt_i
);
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_CLEAR |=> cnt_i == '0);  // R2
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && cmd_i != CMD_CLEAR) |=> $stable(cnt_i));  // R8
  AST_RELOAD_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RELOAD && !edge_i) |=> $stable(cnt_i));  // R1
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && gate_i && cnt_i != '0 && cmd_i != CMD_CLEAR) |=> cnt_i == $past(cnt_i) - 1'b1);  // R3
  AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cnt_i == '0);  // R4
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_ACK |=> !irq_o);  // R5
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cmd_i != CMD_ACK) |=> irq_o);  // R9
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .irq_o (irq_o),
  .gate_i(gate_i),
  .edge_i(a12_rise),
  .cmd_i (cmd),
  .cnt_i (cnt)
);

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        a12_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  scanline_irq_counter u_scanline_irq_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_i),
    .wr_i  (wr_i),
    .data_i(data_i),
    .a12_i (a12_i),
    .gate_i(gate_i),
    .irq_o (irq_o)
  );

  // monitor: pops expected irq levels and compares
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_o !== e) begin
        errors++;
        $display("FAIL %s: irq_o=%0b expected %0b", t, irq_o, e);
      end
    end
  end

  task automatic expect_irq(input bit e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); a12_i = 1'b1;
      repeat (4) @(negedge clk_i);
      a12_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
  endtask

  task automatic rearm();
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_irq(1'b0, "R9 reset");

    // reload 2, three edges to fire
    wr(16'hC000, 8'd2);
    wr(16'hE001, 8'h00);
    pulse(2);
    expect_irq(1'b0, "R4 two edges");
    pulse(1);
    expect_irq(1'b1, "R4 third edge");
    repeat (10) @(negedge clk_i);
    expect_irq(1'b1, "R9 held");
    wr(16'hE000, 8'h00);
    expect_irq(1'b0, "R5 ack");
    wr(16'hE001, 8'h00);
    pulse(2);
    expect_irq(1'b0, "R6 enable no fire");

    // reload 3, clear, reload 4: five edges to fire
    wr(16'hC000, 8'd3);
    wr(16'hC001, 8'hA5);
    wr(16'hC000, 8'd4);
    pulse(4);
    expect_irq(1'b0, "R1 latch at reload time");
    pulse(1);
    expect_irq(1'b1, "R2 fifth edge after clear");

    // long high counts once, falling edge ignored; counter 0, latch 1
    rearm();
    wr(16'hC000, 8'd1);
    @(negedge clk_i); a12_i = 1'b1;
    repeat (20) @(negedge clk_i);
    expect_irq(1'b0, "R10 long high");
    a12_i = 1'b0;
    repeat (8) @(negedge clk_i);
    expect_irq(1'b0, "R10 falling edge");
    pulse(1);
    expect_irq(1'b1, "R10 second rise");

    // gate low blocks edges; counter 0
    rearm();
    gate_i = 1'b0;
    pulse(3);
    expect_irq(1'b0, "R8 gated off");
    gate_i = 1'b1;
    pulse(1);
    expect_irq(1'b0, "R8 first gated edge");
    pulse(1);
    expect_irq(1'b1, "R8 second gated edge");

    // unrelated writes ignored; counter 0 -> edge -> 1
    rearm();
    pulse(1);
    wr(16'hA001, 8'h00);
    wr(16'h8001, 8'hFF);
    wr(16'h6001, 8'h00);
    pulse(1);
    expect_irq(1'b1, "R11 foreign writes");

    // reload 0 fires on every edge
    wr(16'hC000, 8'd0);
    wr(16'hC001, 8'h00);
    rearm();
    pulse(1);
    expect_irq(1'b1, "R7 reload zero first");
    rearm();
    pulse(1);
    expect_irq(1'b1, "R7 reload zero again");

    // disabled: hit is dropped, later enable raises nothing
    wr(16'hE000, 8'h00);
    pulse(1);
    expect_irq(1'b0, "R6 disabled hit");
    wr(16'hE001, 8'h00);
    expect_irq(1'b0, "R6 no late irq");
    pulse(1);
    expect_irq(1'b1, "R6 enabled hit");

    // ack leaves counter running
    wr(16'hC000, 8'd2);
    wr(16'hC001, 8'h00);
    rearm();
    pulse(2);
    rearm();
    pulse(1);
    expect_irq(1'b1, "R5 counter unaffected by ack");

    // reset mid-run clears irq and latch
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    expect_irq(1'b0, "R9 reset clears irq");
    rst_ni = 1'b1;
    wr(16'hE001, 8'h00);
    pulse(1);
    expect_irq(1'b1, "R9 latch reset to zero");

    repeat (4) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule